// File: doc/BRIEF.md
# Memory Transaction Work Accounting Unit

This block measures how well a packet buffer channel uses its data pins. It takes one packet descriptor per cycle: a byte length, a direction (read or write) and a flag saying whether the read hit a bank that was still busy. From these it prices the transfer in word-transactions. The price covers the partly filled last word, the padding out to a whole burst and a fixed bus turnaround charge. A read that collides is also charged the row-cycle stall.

Each priced packet feeds two running totals for its direction. One total holds the useful bytes, which is the sum of the packet lengths. The other holds the work bytes, which is the transactions multiplied by the channel width. Software reads the four totals and divides useful bytes by work bytes to obtain the efficiency. Each total saturates at all-ones instead of wrapping, and each has a sticky flag that records the overflow. A synchronous clear starts a new measurement window.

The channel width, the burst length, the stall window and the minimum packet length are all parameters.

Top module: `mem_work_meter`

## Requirements
- R1: The word count of a packet is its length divided by CHAN_BYTES, rounded up. A partly used last word counts as a full word. A zero-length packet has zero words.
- R2: The word count is rounded up to a multiple of BURST_WORDS. Then 2 turnaround words are added, and the result is `res_xact`. For example, a 5-byte write with CHAN_BYTES=4 and BURST_WORDS=4 gives 6.
- R3: `res_work` equals `res_xact` multiplied by CHAN_BYTES. For the 5-byte example above it is 24.
- R4: A read with `pkt_collide`=1 is charged the larger of two values. The first is its normal count from R2. The second is the floor, which is STALL_SLOTS minus the R2 count of a MIN_PKT_BYTES packet, or zero if that difference is negative. `res_penalty` is 1 exactly when the floor is strictly larger than the normal count. With CHAN_BYTES=4, BURST_WORDS=4, STALL_SLOTS=24 and MIN_PKT_BYTES=40, the floor is 10.
- R5: For a write, `pkt_collide` has no effect. `res_xact` follows R2 and `res_penalty` stays 0.
- R6: When a packet is accepted (`pkt_valid`=1 at a clock edge), `res_valid`, `res_xact`, `res_work` and `res_penalty` show its price after that edge. `res_valid` is 0 after any edge where `pkt_valid` was 0.
- R7: A read adds its length to `rd_useful` and its work to `rd_work`. A write adds to `wr_useful` and `wr_work`. The totals of the other direction do not change.
- R8: If an addition would exceed 2^ACC_W-1, that total holds at all-ones and its bit of `sat_flags` sets. The bit stays set until a clear. The bit order of `sat_flags` is {wr_work, wr_useful, rd_work, rd_useful}, from bit 3 down to bit 0.
- R9: When `acc_clear`=1 at an edge, all four totals and `sat_flags` become zero. This holds even if a packet is accepted at the same edge; that packet is left out of the totals but is still priced on the result outputs.
- R10: After reset, all totals, `sat_flags` and `res_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_clear | input | 1 | Synchronous clear of the totals and saturation flags |
| pkt_valid | input | 1 | A packet descriptor is present this cycle |
| pkt_len | input | LEN_W | Packet length in bytes |
| pkt_is_read | input | 1 | 1 for a read transfer, 0 for a write transfer |
| pkt_collide | input | 1 | The read hit a bank still inside its row-cycle window |
| res_valid | output | 1 | The result outputs hold the price of the last accepted packet |
| res_xact | output | XACT_W | Word-transactions charged to that packet |
| res_work | output | WORK_W | Work in bytes charged to that packet |
| res_penalty | output | 1 | The stall floor set the price |
| rd_useful | output | ACC_W | Sum of read packet lengths |
| rd_work | output | ACC_W | Sum of read work bytes |
| wr_useful | output | ACC_W | Sum of write packet lengths |
| wr_work | output | ACC_W | Sum of write work bytes |
| sat_flags | output | 4 | Sticky overflow flags, one per total |

## Verification
The assertions check these properties on every cycle:
- the result outputs appear one cycle after each accepted packet;
- a result without the stall charge is always a whole number of bursts plus the turnaround;
- the work equals the transactions scaled by the channel width;
- writes never take the stall charge, and colliding reads never fall below the floor;
- a write leaves the read totals untouched;
- a clear empties everything;
- saturation flags stay set until a clear.

Some behaviours can only be shown by the bench's scenarios. These are the exact price of every length from 0 to 2047 for each direction and collision flag, the points where the floor and the burst price cross, and the sums held by the totals while they run into saturation and after a clear that coincides with a packet.

// File: rtl/mwm_pkg.sv
package mwm_pkg;

  // Index of each running total inside the accumulator bank and sat_flags
  typedef enum int unsigned {
    ACC_RD_USE  = 0,
    ACC_RD_WORK = 1,
    ACC_WR_USE  = 2,
    ACC_WR_WORK = 3
  } acc_slot_e;

  localparam int unsigned NUM_ACC = 4;

  // Word-transactions for a transfer: ceil to words, ceil to bursts, add turnaround
  function automatic logic [31:0] xact_count(input logic [31:0] len,
                                             input logic [31:0] chan_bytes,
                                             input logic [31:0] burst_words);
    logic [31:0] words;
    logic [31:0] bursts;
    words  = (len + chan_bytes - 32'd1) / chan_bytes;
    bursts = (words + burst_words - 32'd1) / burst_words;
    return bursts * burst_words + 32'd2;
  endfunction

  // Lowest charge for a colliding read: stall window minus the shortest interleaved write
  function automatic logic [31:0] collide_floor(input logic [31:0] stall_slots,
                                                input logic [31:0] chan_bytes,
                                                input logic [31:0] burst_words,
                                                input logic [31:0] min_len);
    logic [31:0] short_wr;
    short_wr = xact_count(min_len, chan_bytes, burst_words);
    return (stall_slots > short_wr) ? (stall_slots - short_wr) : 32'd0;
  endfunction

endpackage

// File: rtl/mwm_cost.sv
module mwm_cost #(
  parameter int unsigned CHAN_BYTES    = 4,
  parameter int unsigned BURST_WORDS   = 4,
  parameter int unsigned STALL_SLOTS   = 24,
  parameter int unsigned MIN_PKT_BYTES = 40,
  parameter int unsigned LEN_W         = 11,
  parameter int unsigned XACT_W        = 13,
  parameter int unsigned WORK_W        = 16
) (
  input  logic [LEN_W-1:0]  len,
  input  logic              is_read,
  input  logic              collide,
  output logic [XACT_W-1:0] xact,
  output logic [WORK_W-1:0] work,
  output logic              penalty_hit
);
  import mwm_pkg::*;

  localparam logic [31:0] FLOOR =
    collide_floor(STALL_SLOTS, CHAN_BYTES, BURST_WORDS, MIN_PKT_BYTES);

  logic [31:0] base_xact;
  logic [31:0] charged;

  always_comb begin
    base_xact   = xact_count(32'(len), CHAN_BYTES, BURST_WORDS);
    penalty_hit = is_read && collide && (FLOOR > base_xact);
    charged     = penalty_hit ? FLOOR : base_xact;
    xact        = XACT_W'(charged);
    work        = WORK_W'(charged * CHAN_BYTES);
  end

endmodule

// File: rtl/mwm_sat_acc.sv
module mwm_sat_acc #(
  parameter int unsigned ACC_W = 48,
  parameter int unsigned ADD_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             add_en,
  input  logic [ADD_W-1:0] add_val,
  output logic [ACC_W-1:0] total,
  output logic             sat
);
  logic [ACC_W:0] sum;

  assign sum = {1'b0, total} + (ACC_W+1)'(add_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      total <= '0;
      sat   <= 1'b0;
    end else if (clear) begin
      total <= '0;
      sat   <= 1'b0;
    end else if (add_en) begin
      if (sum[ACC_W]) begin
        total <= '1;
        sat   <= 1'b1;
      end else begin
        total <= sum[ACC_W-1:0];
      end
    end
  end

endmodule

// File: rtl/mem_work_meter.sv
module mem_work_meter #(
  parameter int unsigned CHAN_BYTES    = 4,
  parameter int unsigned BURST_WORDS   = 4,
  parameter int unsigned STALL_SLOTS   = 24,
  parameter int unsigned MIN_PKT_BYTES = 40,
  parameter int unsigned LEN_W         = 11,
  parameter int unsigned ACC_W         = 48,
  localparam int unsigned XACT_W       = LEN_W + 2,
  localparam int unsigned WORK_W       = XACT_W + $clog2(CHAN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_clear,
  input  logic              pkt_valid,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_is_read,
  input  logic              pkt_collide,
  output logic              res_valid,
  output logic [XACT_W-1:0] res_xact,
  output logic [WORK_W-1:0] res_work,
  output logic              res_penalty,
  output logic [ACC_W-1:0]  rd_useful,
  output logic [ACC_W-1:0]  rd_work,
  output logic [ACC_W-1:0]  wr_useful,
  output logic [ACC_W-1:0]  wr_work,
  output logic [3:0]        sat_flags
);
  import mwm_pkg::*;

  localparam int unsigned ADD_W = (WORK_W > LEN_W) ? WORK_W : LEN_W;

  // Named internal events
  logic [XACT_W-1:0] cost_xact;
  logic [WORK_W-1:0] cost_work;
  logic              cost_penalty;
  logic [NUM_ACC-1:0] acc_add_en;
  logic [ADD_W-1:0]   acc_add_val [NUM_ACC];
  logic [ACC_W-1:0]   acc_total   [NUM_ACC];

  mwm_cost #(
    .CHAN_BYTES   (CHAN_BYTES),
    .BURST_WORDS  (BURST_WORDS),
    .STALL_SLOTS  (STALL_SLOTS),
    .MIN_PKT_BYTES(MIN_PKT_BYTES),
    .LEN_W        (LEN_W),
    .XACT_W       (XACT_W),
    .WORK_W       (WORK_W)
  ) u_cost (
    .len        (pkt_len),
    .is_read    (pkt_is_read),
    .collide    (pkt_collide),
    .xact       (cost_xact),
    .work       (cost_work),
    .penalty_hit(cost_penalty)
  );

  // Result stage: one register between the accepted descriptor and its price
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_xact    <= '0;
      res_work    <= '0;
      res_penalty <= 1'b0;
    end else begin
      res_valid <= pkt_valid;
      if (pkt_valid) begin
        res_xact    <= cost_xact;
        res_work    <= cost_work;
        res_penalty <= cost_penalty;
      end
    end
  end

  // Four saturating totals: slots 0,1 read; slots 2,3 write; even = useful, odd = work
  for (genvar gi = 0; gi < NUM_ACC; gi++) begin : g_acc
    localparam bit SLOT_READ = (gi < 2);

    assign acc_add_en[gi] = pkt_valid && (pkt_is_read == SLOT_READ);

    if (gi % 2 == 0) begin : g_useful
      assign acc_add_val[gi] = ADD_W'(pkt_len);
    end else begin : g_work
      assign acc_add_val[gi] = ADD_W'(cost_work);
    end

    mwm_sat_acc #(
      .ACC_W(ACC_W),
      .ADD_W(ADD_W)
    ) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (acc_clear),
      .add_en (acc_add_en[gi]),
      .add_val(acc_add_val[gi]),
      .total  (acc_total[gi]),
      .sat    (sat_flags[gi])
    );
  end

  assign rd_useful = acc_total[ACC_RD_USE];
  assign rd_work   = acc_total[ACC_RD_WORK];
  assign wr_useful = acc_total[ACC_WR_USE];
  assign wr_work   = acc_total[ACC_WR_WORK];

endmodule

// File: rtl/mwm_checker.sv
module mwm_checker #(
  parameter int unsigned CHAN_BYTES    = 4,
  parameter int unsigned BURST_WORDS   = 4,
  parameter int unsigned STALL_SLOTS   = 24,
  parameter int unsigned MIN_PKT_BYTES = 40,
  parameter int unsigned LEN_W         = 11,
  parameter int unsigned ACC_W         = 48,
  parameter int unsigned XACT_W        = 13,
  parameter int unsigned WORK_W        = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_clear,
  input logic              pkt_valid,
  input logic [LEN_W-1:0]  pkt_len,
  input logic              pkt_is_read,
  input logic              pkt_collide,
  input logic              res_valid,
  input logic [XACT_W-1:0] res_xact,
  input logic [WORK_W-1:0] res_work,
  input logic              res_penalty,
  input logic [ACC_W-1:0]  rd_useful,
  input logic [ACC_W-1:0]  rd_work,
  input logic [ACC_W-1:0]  wr_useful,
  input logic [ACC_W-1:0]  wr_work,
  input logic [3:0]        sat_flags
);
  import mwm_pkg::*;

  localparam logic [31:0] FLOOR =
    collide_floor(STALL_SLOTS, CHAN_BYTES, BURST_WORDS, MIN_PKT_BYTES);

  logic [LEN_W-1:0] unused_len;
  assign unused_len = pkt_len;

  // R6
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> res_valid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !res_valid);

  // R2
  burst_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_penalty) |->
      (32'(res_xact) >= 32'd2) && (((32'(res_xact) - 32'd2) % BURST_WORDS) == 32'd0));

  // R3
  work_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (32'(res_work) == 32'(res_xact) * CHAN_BYTES));

  // R5
  wr_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_is_read) |=> !res_penalty);

  // R4
  stall_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_is_read && pkt_collide) |=> (32'(res_xact) >= FLOOR));

  // R7
  wr_path_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_is_read && !acc_clear) |=> ($stable(rd_useful) && $stable(rd_work)));

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clear |=> ((rd_useful == '0) && (rd_work == '0) && (wr_useful == '0) &&
                   (wr_work == '0) && (sat_flags == 4'd0)));

  // R8
  sat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sat_flags != 4'd0) && !acc_clear) |=> ((sat_flags & $past(sat_flags)) == $past(sat_flags)));

endmodule

bind mem_work_meter mwm_checker #(
  .CHAN_BYTES   (CHAN_BYTES),
  .BURST_WORDS  (BURST_WORDS),
  .STALL_SLOTS  (STALL_SLOTS),
  .MIN_PKT_BYTES(MIN_PKT_BYTES),
  .LEN_W        (LEN_W),
  .ACC_W        (ACC_W),
  .XACT_W       (XACT_W),
  .WORK_W       (WORK_W)
) u_mwm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_clear  (acc_clear),
  .pkt_valid  (pkt_valid),
  .pkt_len    (pkt_len),
  .pkt_is_read(pkt_is_read),
  .pkt_collide(pkt_collide),
  .res_valid  (res_valid),
  .res_xact   (res_xact),
  .res_work   (res_work),
  .res_penalty(res_penalty),
  .rd_useful  (rd_useful),
  .rd_work    (rd_work),
  .wr_useful  (wr_useful),
  .wr_work    (wr_work),
  .sat_flags  (sat_flags)
);

// File: tb/tb_mem_work_meter.sv
module tb_mem_work_meter;
  localparam int LEN_W  = 11;
  localparam int ACC_W  = 16;
  localparam int XACT_W = LEN_W + 2;
  localparam int WORK_W = XACT_W + 3;   // clog2(4+1) = 3
  localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;
  // Floor for colliding reads: 24 slots minus the 40-byte price (10 words -> 12 + 2 = 14)
  localparam int FLOOR_EXP = 24 - 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_clear = 1'b0;
  logic pkt_valid = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic pkt_is_read = 1'b0;
  logic pkt_collide = 1'b0;
  logic res_valid;
  logic [XACT_W-1:0] res_xact;
  logic [WORK_W-1:0] res_work;
  logic res_penalty;
  logic [ACC_W-1:0] rd_useful, rd_work, wr_useful, wr_work;
  logic [3:0] sat_flags;

  always #5 clk = ~clk;

  mem_work_meter #(
    .CHAN_BYTES(4), .BURST_WORDS(4), .STALL_SLOTS(24), .MIN_PKT_BYTES(40),
    .LEN_W(LEN_W), .ACC_W(ACC_W)
  ) dut (
    .clk(clk), .rst_n(rst_n), .acc_clear(acc_clear), .pkt_valid(pkt_valid),
    .pkt_len(pkt_len), .pkt_is_read(pkt_is_read), .pkt_collide(pkt_collide),
    .res_valid(res_valid), .res_xact(res_xact), .res_work(res_work),
    .res_penalty(res_penalty), .rd_useful(rd_useful), .rd_work(rd_work),
    .wr_useful(wr_useful), .wr_work(wr_work), .sat_flags(sat_flags)
  );

  int checks = 0;
  int failures = 0;
  longint m_tot [4];
  bit     m_sat [4];

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Price restated as integer arithmetic on 4-byte words and 4-word bursts
  function automatic int price(input int len, input bit rd, input bit col, output bit pen);
    int words, padded, t;
    words  = len / 4 + ((len % 4 != 0) ? 1 : 0);
    padded = ((words + 3) / 4) * 4;
    t      = padded + 2;
    pen    = rd && col && (FLOOR_EXP > t);
    return pen ? FLOOR_EXP : t;
  endfunction

  task automatic model_add(input int slot, input longint v);
    if (m_tot[slot] + v > ACC_MAX) begin
      m_tot[slot] = ACC_MAX;
      m_sat[slot] = 1'b1;
    end else begin
      m_tot[slot] = m_tot[slot] + v;
    end
  endtask

  task automatic check_totals(input string req);
    check(req, rd_useful, m_tot[0]);
    check(req, rd_work,   m_tot[1]);
    check(req, wr_useful, m_tot[2]);
    check(req, wr_work,   m_tot[3]);
    check(req, sat_flags, {m_sat[3], m_sat[2], m_sat[1], m_sat[0]});
  endtask

  // Called just after a falling edge; drives one packet and checks it at the next falling edge
  task automatic send(input int len, input bit rd, input bit col, input bit clr);
    int  x;
    bit  pen;
    pkt_valid   = 1'b1;
    pkt_len     = LEN_W'(len);
    pkt_is_read = rd;
    pkt_collide = col;
    acc_clear   = clr;
    @(negedge clk);
    x = price(len, rd, col, pen);
    check("R6 res_valid", res_valid, 1);
    check(pen ? "R4 xact" : (rd ? "R1/R2 read xact" : "R1/R2/R5 write xact"), res_xact, x);
    check("R3 work", res_work, x * 4);
    check(rd ? "R4 penalty" : "R5 penalty", res_penalty, pen);
    if (clr) begin
      for (int i = 0; i < 4; i++) begin m_tot[i] = 0; m_sat[i] = 1'b0; end
      check_totals("R9 clear");
    end else begin
      model_add(rd ? 0 : 2, len);
      model_add(rd ? 1 : 3, x * 4);
      check_totals("R7/R8 totals");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_tot[i] = 0; m_sat[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 res_valid", res_valid, 0);
    check_totals("R10 totals");

    // Worked example: 5-byte write -> 6 transactions, 24 work bytes (R1 R2 R3)
    send(5, 1'b0, 1'b0, 1'b0);
    check("R1 worked xact", res_xact, 6);
    check("R3 worked work", res_work, 24);
    // Zero length and exact multiples
    send(0, 1'b1, 1'b0, 1'b0);
    send(16, 1'b0, 1'b0, 1'b0);
    send(17, 1'b0, 1'b0, 1'b0);

    // Write sweep, collide flag toggling (R5), totals run into saturation (R8)
    for (int len = 0; len < 2048; len++) send(len, 1'b0, len[0], 1'b0);

    // Clear coinciding with a packet (R9)
    send(100, 1'b0, 1'b0, 1'b1);
    send(100, 1'b1, 1'b1, 1'b1);

    // Read sweeps without and with collision (R1 R2 R4 R7 R8)
    for (int len = 0; len < 2048; len++) send(len, 1'b1, 1'b0, 1'b0);
    send(0, 1'b0, 1'b0, 1'b1);
    for (int len = 0; len < 2048; len++) send(len, 1'b1, 1'b1, 1'b0);

    // Idle cycle: no result, totals held (R6 R7)
    pkt_valid = 1'b0;
    acc_clear = 1'b0;
    @(negedge clk);
    check("R6 idle res_valid", res_valid, 0);
    check_totals("R7 idle totals");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule